// File: doc/BRIEF.md
# Permit Carrier Repeater

This block is one station of a serial permit chain. Upstream stations pass permission downstream as a square-wave carrier, not as a level. The block watches the incoming carrier on its system clock. It regenerates a fresh carrier of the same frequency downstream only while all of these hold: the incoming carrier is alive, every enabled local permit input is high, and an operator reset event has armed the station. If the carrier stops or an enabled input drops, the downstream carrier goes quiet at once. It stays quiet until the next operator reset event, even after the cause has gone away.

Each local input that fails is latched in a fault bitmap. The value of a free-running 32-bit cycle counter is stored with it at the moment of failure. Only the first failure after a reset event is stamped; later glitches on the same input leave the stored stamp as it is. Firmware reads the bitmap directly and selects one stored stamp at a time through a small read port. A mask input removes unused inputs from the permit decision and from fault latching. The decoded operator reset strobe arrives already decoded as a one-cycle input. All local permit inputs, the mask and the strobe are synchronous to `clk`. The incoming carrier is asynchronous and is synchronised inside the block.

Top module: `permit_repeater`

## Requirements
- R1: `carrier_ok` rises after edges appear on `carrier_in`. It falls when no edge has been seen for CARRIER_DIV*LOSS_PERIODS clock cycles (40 cycles with the defaults), counted after a three-stage input synchroniser.
- R2: Loss of the incoming carrier clears `permit_out` within one cycle. `permit_out` stays low after the carrier returns until an operator reset event.
- R3: An input i with `mask_in[i]`=1 that is sampled low sets `fault_map[i]` and clears `permit_out` at the same clock edge.
- R4: An input with `mask_in[i]`=0 never sets its fault bit and does not affect `permit_out`.
- R5: A newly latched fault stores the timestamp counter value of the edge that sampled the failure. Two faults sampled D cycles apart therefore hold stamps that differ by exactly D.
- R6: While `fault_map[i]` is set, further low samples on input i do not change its stored stamp.
- R7: Reset state: `permit_out`=0, `fault_map`=0 and `carrier_out`=0. Only a cycle with `op_reset`=1 clears `fault_map` and sets `permit_out`. It sets `permit_out` only if, in that cycle, the carrier is present and every enabled input is high.
- R8: While `permit_out`=1, `carrier_out` toggles every CARRIER_DIV/2 cycles (5 with the defaults). While `permit_out`=0, `carrier_out` is held low from the next cycle.
- R9: `rd_stamp` shows the stored stamp of input number `rd_sel` in the same cycle. Bit i of `fault_map` belongs to input i.
- R10: If `op_reset`=1 and an enabled input is low in the same cycle, the clear happens first. The input is then latched afresh with that cycle's stamp, and `permit_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_in | input | 1 | Incoming permit carrier, asynchronous |
| permit_in | input | N_IN | Local permit inputs, 1 = permitting |
| mask_in | input | N_IN | 1 = input takes part in the permit and in fault latching |
| op_reset | input | 1 | Decoded operator reset event, one-cycle strobe |
| rd_sel | input | SEL_W | Input number whose stored stamp is read |
| carrier_out | output | 1 | Regenerated downstream carrier |
| carrier_ok | output | 1 | Incoming carrier currently judged present |
| permit_out | output | 1 | Armed permit state of this station |
| fault_map | output | N_IN | Latched fault bitmap |
| rd_stamp | output | 32 | Stored failure stamp of input `rd_sel` |

## Verification
Two things can land on the same clock edge: the operator reset event clearing the latches, and a fresh failure being captured on an input that is still low. The bench first latches a fault on one input and keeps that input low. It then pulses the reset event, and exactly three cycles later fails a second input. The stamp difference must equal three, which proves the first input was cleared and re-stamped on the reset edge rather than keeping its old stamp. `permit_out` must stay low and the bitmap must hold only those two bits.

// File: rtl/permit_repeater_pkg.sv
package permit_repeater_pkg;

    localparam int unsigned STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    // One latch slot per local input
    typedef struct packed {
        logic   hit;
        stamp_t ts;
    } slot_t;

endpackage

// File: rtl/permit_carrier_detect.sv
module permit_carrier_detect #(
    parameter int unsigned DIV          = 10,
    parameter int unsigned LOSS_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_in,
    output logic present_o
);

    localparam int unsigned LIMIT = DIV * LOSS_PERIODS;
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          present;
    } det_t;

    det_t det_d, det_q;
    logic edge_seen;

    assign edge_seen = det_q.sync[2] ^ det_q.sync[1];

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[1:0], carrier_in};
        if (edge_seen) begin
            det_d.cnt     = '0;
            det_d.present = 1'b1;
        end else if (det_q.present) begin
            if (det_q.cnt == CW'(LIMIT - 1)) begin
                det_d.present = 1'b0;
                det_d.cnt     = '0;
            end else begin
                det_d.cnt = det_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign present_o = det_q.present;

endmodule

// File: rtl/permit_carrier_gen.sv
module permit_carrier_gen #(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic carrier_o
);

    localparam int unsigned HALF = (DIV / 2 > 0) ? DIV / 2 : 1;
    localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          phase;
        logic          out;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d     = gen_q;
        gen_d.out = enable_i & gen_q.phase;
        if (gen_q.cnt == HW'(HALF - 1)) begin
            gen_d.cnt   = '0;
            gen_d.phase = ~gen_q.phase;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign carrier_o = gen_q.out;

endmodule

// File: rtl/permit_fault_bank.sv
module permit_fault_bank
    import permit_repeater_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] fail_i,
    input  logic            clear_i,
    input  stamp_t          now_i,
    output logic [N_IN-1:0] fault_o,
    output stamp_t          stamp_o [N_IN]
);

    for (genvar i = 0; i < N_IN; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            // clear first, so a still-failing input is stamped again
            if (clear_i) slot_d.hit = 1'b0;
            if (fail_i[i] && !slot_d.hit) begin
                slot_d.hit = 1'b1;
                slot_d.ts  = now_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign fault_o[i] = slot_q.hit;
        assign stamp_o[i] = slot_q.ts;
    end

endmodule

// File: rtl/permit_repeater.sv
module permit_repeater
    import permit_repeater_pkg::*;
#(
    parameter int unsigned N_IN         = 8,
    parameter int unsigned CARRIER_DIV  = 10,
    parameter int unsigned LOSS_PERIODS = 4,
    localparam int unsigned SEL_W       = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_in,
    input  logic [N_IN-1:0]  permit_in,
    input  logic [N_IN-1:0]  mask_in,
    input  logic             op_reset,
    input  logic [SEL_W-1:0] rd_sel,
    output logic             carrier_out,
    output logic             carrier_ok,
    output logic             permit_out,
    output logic [N_IN-1:0]  fault_map,
    output logic [31:0]      rd_stamp
);

    typedef struct packed {
        stamp_t now;
        logic   permit;
    } top_t;

    top_t top_d, top_q;

    logic [N_IN-1:0] fail_now;
    logic            all_good;
    stamp_t          stamps [N_IN];

    assign fail_now = ~permit_in & mask_in;
    assign all_good = carrier_ok && (fail_now == '0);

    permit_carrier_detect #(
        .DIV          (CARRIER_DIV),
        .LOSS_PERIODS (LOSS_PERIODS)
    ) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_in (carrier_in),
        .present_o  (carrier_ok)
    );

    permit_fault_bank #(
        .N_IN (N_IN)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_i  (fail_now),
        .clear_i (op_reset),
        .now_i   (top_q.now),
        .fault_o (fault_map),
        .stamp_o (stamps)
    );

    permit_carrier_gen #(
        .DIV (CARRIER_DIV)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (top_q.permit),
        .carrier_o (carrier_out)
    );

    always_comb begin
        top_d     = top_q;
        top_d.now = top_q.now + 1'b1;
        if (op_reset) top_d.permit = all_good;
        else          top_d.permit = top_q.permit & all_good;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign permit_out = top_q.permit;
    assign rd_stamp   = (32'(rd_sel) < N_IN) ? stamps[rd_sel] : '0;

endmodule

// File: rtl/permit_repeater_chk.sv
module permit_repeater_chk #(
    parameter int unsigned N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_reset,
    input logic [N_IN-1:0] permit_in,
    input logic [N_IN-1:0] mask_in,
    input logic            carrier_ok,
    input logic            permit_out,
    input logic            carrier_out,
    input logic [N_IN-1:0] fault_map
);

    AST_PERMIT_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(permit_out) |-> $past(op_reset)); // R7

    AST_FAULTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !op_reset |=> ((fault_map & $past(fault_map)) == $past(fault_map))); // R7

    AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_map & ~$past(fault_map) & ~$past(mask_in)) == '0)); // R4

    AST_NO_PERMIT_WITHOUT_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> !permit_out); // R2

    AST_FAIL_DROPS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((~permit_in & mask_in) != '0) |=> !permit_out); // R3

    AST_CARRIER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !permit_out |=> !carrier_out); // R8

endmodule

bind permit_repeater permit_repeater_chk #(.N_IN(N_IN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_reset    (op_reset),
    .permit_in   (permit_in),
    .mask_in     (mask_in),
    .carrier_ok  (carrier_ok),
    .permit_out  (permit_out),
    .carrier_out (carrier_out),
    .fault_map   (fault_map)
);

// File: tb/permit_repeater_bench.sv
module permit_repeater_bench;

    localparam int N_IN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier_in = 1'b0;
    logic [7:0]  permit_in = 8'hFF;
    logic [7:0]  mask_in = 8'hFF;
    logic        op_reset = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic        carrier_out, carrier_ok, permit_out;
    logic [7:0]  fault_map;
    logic [31:0] rd_stamp;

    logic car_en = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    permit_repeater #(.N_IN(N_IN)) u_permit_repeater (
        .clk         (clk),
        .rst_n       (rst_n),
        .carrier_in  (carrier_in),
        .permit_in   (permit_in),
        .mask_in     (mask_in),
        .op_reset    (op_reset),
        .rd_sel      (rd_sel),
        .carrier_out (carrier_out),
        .carrier_ok  (carrier_ok),
        .permit_out  (permit_out),
        .fault_map   (fault_map),
        .rd_stamp    (rd_stamp)
    );

    // 5 MHz carrier source: half period of 5 system cycles
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (car_en) carrier_in = ~carrier_in;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_event();
        @(negedge clk) op_reset = 1'b1;
        @(negedge clk) op_reset = 1'b0;
    endtask

    task automatic count_out_edges(input int cycles, output int edges);
        logic prev;
        edges = 0;
        @(negedge clk) prev = carrier_out;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (carrier_out != prev) edges++;
            prev = carrier_out;
        end
    endtask

    task automatic read_stamp(input int idx, output logic [31:0] v);
        rd_sel = 3'(idx);
        #1 v = rd_stamp;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(permit_out == 1'b0, "R7 reset permit", permit_out, 0);
        check(fault_map == 8'h00, "R7 reset faults", fault_map, 0);
        check(carrier_out == 1'b0, "R7 reset carrier_out", carrier_out, 0);
        check(carrier_ok == 1'b0, "R1 no carrier yet", carrier_ok, 0);
    endtask

    task automatic t_presence_and_arm();
        int e;
        car_en = 1'b1;
        repeat (60) @(negedge clk);
        check(carrier_ok == 1'b1, "R1 carrier detected", carrier_ok, 1);
        check(permit_out == 1'b0, "R7 no permit before event", permit_out, 0);
        pulse_event();
        check(permit_out == 1'b1, "R7 event arms permit", permit_out, 1);
        count_out_edges(100, e);
        check(e >= 19 && e <= 21, "R8 regenerated carrier edges", e, 20);
    endtask

    task automatic t_fault_latch();
        int e;
        @(negedge clk) permit_in[0] = 1'b0;
        @(negedge clk) permit_in[0] = 1'b1;
        check(fault_map == 8'h01, "R3 R9 fault bit 0", fault_map, 1);
        check(permit_out == 1'b0, "R3 permit dropped", permit_out, 0);
        count_out_edges(50, e);
        check(e == 0 && carrier_out == 1'b0, "R8 carrier quiet", e, 0);
        check(permit_out == 1'b0 && fault_map == 8'h01, "R7 no self recovery", fault_map, 1);
    endtask

    task automatic t_stamps();
        logic [31:0] s1, s4, s1b;
        pulse_event();
        check(fault_map == 8'h00 && permit_out == 1'b1, "R7 event clears", fault_map, 0);
        @(negedge clk) permit_in[1] = 1'b0;
        @(negedge clk) permit_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        permit_in[4] = 1'b0;
        @(negedge clk) permit_in[4] = 1'b1;
        read_stamp(1, s1);
        read_stamp(4, s4);
        check(s4 - s1 == 32'd7, "R5 R9 stamp difference", s4 - s1, 7);
        check(fault_map == 8'h12, "R9 fault bitmap", fault_map, 8'h12);
        repeat (3) @(negedge clk);
        permit_in[1] = 1'b0;
        @(negedge clk) permit_in[1] = 1'b1;
        read_stamp(1, s1b);
        check(s1b == s1, "R6 stamp kept on glitch", s1b, s1);
    endtask

    task automatic t_mask();
        mask_in = 8'hBF;
        pulse_event();
        check(permit_out == 1'b1, "R7 rearm", permit_out, 1);
        @(negedge clk) permit_in[6] = 1'b0;
        repeat (10) @(negedge clk);
        check(fault_map == 8'h00, "R4 masked no fault", fault_map, 0);
        check(permit_out == 1'b1, "R4 masked no drop", permit_out, 1);
        permit_in[6] = 1'b1;
        mask_in = 8'hFF;
    endtask

    task automatic t_carrier_loss();
        car_en = 1'b0;
        repeat (30) @(negedge clk);
        check(carrier_ok == 1'b1, "R1 carrier held within window", carrier_ok, 1);
        repeat (20) @(negedge clk);
        check(carrier_ok == 1'b0, "R1 carrier lost", carrier_ok, 0);
        check(permit_out == 1'b0, "R2 permit dropped on loss", permit_out, 0);
        car_en = 1'b1;
        repeat (60) @(negedge clk);
        check(carrier_ok == 1'b1, "R1 carrier back", carrier_ok, 1);
        check(permit_out == 1'b0, "R2 stays low after return", permit_out, 0);
        pulse_event();
        check(permit_out == 1'b1, "R2 event rearms", permit_out, 1);
    endtask

    task automatic t_collide();
        logic [31:0] s2, s5;
        @(negedge clk) permit_in[2] = 1'b0;
        repeat (20) @(negedge clk);
        pulse_event();
        repeat (2) @(negedge clk);
        permit_in[5] = 1'b0;
        @(negedge clk) permit_in[5] = 1'b1;
        read_stamp(2, s2);
        read_stamp(5, s5);
        check(s5 - s2 == 32'd3, "R10 restamped on event edge", s5 - s2, 3);
        check(fault_map == 8'h24, "R10 bitmap", fault_map, 8'h24);
        check(permit_out == 1'b0, "R10 permit stays low", permit_out, 0);
        permit_in[2] = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_presence_and_arm();
        t_fault_latch();
        t_stamps();
        t_mask();
        t_carrier_loss();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule